// File: doc/BRIEF.md
# Receive-Side Scaling Queue Selector

This block decides which processor or receive queue should handle an arriving packet. Each time the packet-valid strobe is high, it takes the parsed source and destination addresses and ports. A configured hash type picks which of these fields take part. The block runs a keyed Toeplitz hash over the chosen bits and ANDs the low bits of the result with a programmable mask. The masked value selects one entry of a programmable indirection table, and a programmable base number is added to that entry to form the queue number.

The result appears a fixed number of cycles after the strobe, together with the raw hash and a one-cycle valid. The mask and base number are captured when the packet is accepted. Software may therefore change them while earlier packets are still in the pipeline. The table is loaded through its own write port. A hash type of "none" bypasses hashing, and the queue number is then the base number.

Top module: `rss_queue_sel`

## Requirements
- R1: While reset is active, and after it is released until the first packet result, `out_valid`, `out_queue` and `out_hash` are 0. After reset every indirection table entry holds 0.
- R2: `hash_type` encoding: 1 hashes the 64-bit string {src_addr, dst_addr}. 2 hashes the 96-bit string {src_addr, dst_addr, src_port, dst_port}. Under type 1 the port inputs have no effect on `out_hash` or `out_queue`.
- R3: The hash is Toeplitz. It starts at 0 and walks the input string from its most significant bit. For input bit i (i=0 first), if the bit is 1 the result is XORed with key bits [319-i : 288-i]. Key bit 319 is the leftmost key bit.
- R4: The table index is `out_hash[6:0] & hash_mask`, with the mask taken from the accepting cycle. A mask of 0 always selects entry 0.
- R5: For hashing types, `out_queue` = (base + table[index]) mod 256, with the 7-bit entry zero-extended.
- R6: `hash_type` 0 and the reserved code 3 give `out_queue` = base and `out_hash` = 0, whatever the table and fields hold.
- R7: A packet accepted at a rising edge gives `out_valid` high for exactly one cycle after the third rising edge, counting the accepting edge. Packets on consecutive cycles each give their own result in order.
- R8: When `tbl_we` is high at a rising edge, entry `tbl_addr` takes `tbl_wdata`. Packets accepted at later edges see the new value.
- R9: `hash_mask` and `base_cpu` are sampled at the accepting edge. Changing them afterwards does not alter that packet's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pkt_valid | input | 1 | Packet fields valid; one packet accepted per high cycle |
| src_addr | input | 32 | Source address |
| dst_addr | input | 32 | Destination address |
| src_port | input | 16 | Source port |
| dst_port | input | 16 | Destination port |
| hash_type | input | 2 | 0 none, 1 addresses, 2 addresses and ports, 3 treated as none |
| hash_key | input | 320 | Secret hash key, bit 319 first |
| hash_mask | input | 7 | Mask ANDed with the low hash bits to form the table index |
| base_cpu | input | 8 | Number added to the table entry |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 7 | Table write address |
| tbl_wdata | input | 7 | Table write data |
| out_valid | output | 1 | Result valid |
| out_queue | output | 8 | Selected processor or queue number |
| out_hash | output | 32 | Raw hash of the packet |

## Verification
A published key with a known address-and-port tuple fixes the bit order and key alignment of the hash, because any swap of fields or shift of the key window changes the 32-bit value. The same tuple under the address-only type, with the ports then altered, shows that the type selects the string length and that ports are dropped. Random-looking tuples are checked against a bench model with a full-range mask and a narrow mask, over a table filled with a non-linear pattern, so a wrong index bit gives a different queue. Further cases cover both "none" codes, a base that wraps past 255, back-to-back packets with different settings, and settings changed right after acceptance; each separates sampled from live configuration.

// File: rtl/rss_pkg.sv
package rss_pkg;
  typedef enum logic [1:0] {
    HT_NONE      = 2'd0,
    HT_ADDR      = 2'd1,
    HT_ADDR_PORT = 2'd2,
    HT_RSVD      = 2'd3
  } hash_sel_e;

  localparam int ADDR_W  = 32;
  localparam int PORT_W  = 16;
  localparam int TUPLE_W = 2 * ADDR_W + 2 * PORT_W;
endpackage

// File: rtl/rss_toeplitz.sv
module rss_toeplitz #(
  parameter int IN_W   = 96,
  parameter int KEY_W  = 320,
  parameter int HASH_W = 32
) (
  input  logic [IN_W-1:0]   data_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic [HASH_W-1:0] hash_o
);
  // Key must cover every window position that an input bit can reach.
  if (KEY_W < IN_W + HASH_W - 1) begin : g_key_too_short
    initial $error("rss_toeplitz: key shorter than input plus hash width");
  end

  always_comb begin
    hash_o = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (data_i[IN_W-1-i]) begin
        hash_o = hash_o ^ key_i[KEY_W-1-i -: HASH_W];
      end
    end
  end

  // R6: an all-zero string (hash bypass) must give a zero hash.
  always_comb begin
    if (data_i == '0) begin
      a_r6_zero_string_zero_hash : assert (hash_o == '0);
    end
  end
endmodule

// File: rtl/rss_indir_tbl.sv
module rss_indir_tbl #(
  parameter int DEPTH = 128,
  parameter int ENT_W = 7,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ENT_W-1:0] rdata_o
);
  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [ENT_W-1:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (we_i) begin
      mem_d[waddr_i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
    end else if (we_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= mem_d[i];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R8: a read of the address written on the previous edge returns that data.
  a_r8_write_visible : assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (raddr_i == waddr_i)) |=> ($past(raddr_i) != raddr_i) || (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/rss_queue_sel.sv
module rss_queue_sel #(
  parameter int KEY_W  = 320,
  parameter int HASH_W = 32,
  parameter int DEPTH  = 128,
  parameter int ENT_W  = 7,
  parameter int QW     = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [31:0]       src_addr,
  input  logic [31:0]       dst_addr,
  input  logic [15:0]       src_port,
  input  logic [15:0]       dst_port,
  input  logic [1:0]        hash_type,
  input  logic [KEY_W-1:0]  hash_key,
  input  logic [AW-1:0]     hash_mask,
  input  logic [QW-1:0]     base_cpu,
  input  logic              tbl_we,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [ENT_W-1:0]  tbl_wdata,
  output logic              out_valid,
  output logic [QW-1:0]     out_queue,
  output logic [HASH_W-1:0] out_hash
);
  import rss_pkg::*;

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // Stage 1: field selection and configuration capture.
  logic               s1_vld_q, s1_vld_d;
  logic [TUPLE_W-1:0] s1_tuple_q, s1_tuple_d;
  logic               s1_none_q, s1_none_d;
  logic [AW-1:0]      s1_mask_q, s1_mask_d;
  logic [QW-1:0]      s1_base_q, s1_base_d;

  always_comb begin
    s1_vld_d  = pkt_valid;
    s1_mask_d = hash_mask;
    s1_base_d = base_cpu;
    unique case (hash_sel_e'(hash_type))
      HT_ADDR: begin
        s1_tuple_d = {src_addr, dst_addr, {(2*PORT_W){1'b0}}};
        s1_none_d  = 1'b0;
      end
      HT_ADDR_PORT: begin
        s1_tuple_d = {src_addr, dst_addr, src_port, dst_port};
        s1_none_d  = 1'b0;
      end
      default: begin
        s1_tuple_d = '0;
        s1_none_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s1_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s1_tuple_q <= '0;
      s1_none_q  <= 1'b1;
      s1_mask_q  <= '0;
      s1_base_q  <= '0;
    end else if (pkt_valid) begin
      s1_tuple_q <= s1_tuple_d;
      s1_none_q  <= s1_none_d;
      s1_mask_q  <= s1_mask_d;
      s1_base_q  <= s1_base_d;
    end
  end

  // Stage 2: keyed hash and index masking.
  logic [HASH_W-1:0] hash_w;

  rss_toeplitz #(.IN_W(TUPLE_W), .KEY_W(KEY_W), .HASH_W(HASH_W)) u_hash (
    .data_i (s1_tuple_q),
    .key_i  (hash_key),
    .hash_o (hash_w)
  );

  logic              s2_vld_q;
  logic [HASH_W-1:0] s2_hash_q, s2_hash_d;
  logic [AW-1:0]     s2_idx_q, s2_idx_d;
  logic              s2_none_q;
  logic [QW-1:0]     s2_base_q;

  always_comb begin
    s2_hash_d = hash_w;
    s2_idx_d  = hash_w[AW-1:0] & s1_mask_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s2_vld_q <= 1'b0;
    end else begin
      s2_vld_q <= s1_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s2_hash_q <= '0;
      s2_idx_q  <= '0;
      s2_none_q <= 1'b1;
      s2_base_q <= '0;
    end else if (s1_vld_q) begin
      s2_hash_q <= s2_hash_d;
      s2_idx_q  <= s2_idx_d;
      s2_none_q <= s1_none_q;
      s2_base_q <= s1_base_q;
    end
  end

  // Stage 3: table lookup and base offset.
  logic [ENT_W-1:0] tbl_rdata;

  rss_indir_tbl #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_sn),
    .we_i    (tbl_we),
    .waddr_i (tbl_addr),
    .wdata_i (tbl_wdata),
    .raddr_i (s2_idx_q),
    .rdata_o (tbl_rdata)
  );

  logic              out_vld_q;
  logic [QW-1:0]     out_queue_q, out_queue_d;
  logic [HASH_W-1:0] out_hash_q;

  always_comb begin
    if (s2_none_q) out_queue_d = s2_base_q;
    else           out_queue_d = s2_base_q + QW'(tbl_rdata);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_vld_q <= 1'b0;
    end else begin
      out_vld_q <= s2_vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_queue_q <= '0;
      out_hash_q  <= '0;
    end else if (s2_vld_q) begin
      out_queue_q <= out_queue_d;
      out_hash_q  <= s2_hash_q;
    end
  end

  assign out_valid = out_vld_q;
  assign out_queue = out_queue_q;
  assign out_hash  = out_hash_q;

  // R7: every accepted packet yields a result three edges later.
  a_r7_fixed_latency : assert property (@(posedge clk) disable iff (!rst_sn)
    pkt_valid |=> ##1 ##1 out_valid);

  // R7: no result without a packet accepted three edges earlier.
  a_r7_no_spurious : assert property (@(posedge clk) disable iff (!rst_sn)
    out_valid |-> $past(pkt_valid, 3));

  // R6 and R9: bypass types return the base sampled at acceptance.
  a_r6_bypass_base : assert property (@(posedge clk) disable iff (!rst_sn)
    (pkt_valid && (hash_type == HT_NONE || hash_type == HT_RSVD)) |=> ##1 ##1
    ((out_queue == $past(base_cpu, 3)) && (out_hash == '0)));

  // R1: nothing leaves the block while no packet has been seen.
  a_r1_quiet_after_reset : assert property (@(posedge clk) disable iff (!rst_sn)
    (!out_valid && !s2_vld_q) |=> !out_valid);
endmodule

// File: tb/tb_rss_queue_sel.sv
module tb_rss_queue_sel;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         pkt_valid;
  logic [31:0]  src_addr, dst_addr;
  logic [15:0]  src_port, dst_port;
  logic [1:0]   hash_type;
  logic [319:0] hash_key;
  logic [6:0]   hash_mask;
  logic [7:0]   base_cpu;
  logic         tbl_we;
  logic [6:0]   tbl_addr, tbl_wdata;
  logic         out_valid;
  logic [7:0]   out_queue;
  logic [31:0]  out_hash;

  int n_checks = 0;
  int n_fail   = 0;
  logic [6:0] tbl_model [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  rss_queue_sel dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_port(src_port), .dst_port(dst_port),
    .hash_type(hash_type), .hash_key(hash_key), .hash_mask(hash_mask), .base_cpu(base_cpu),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_queue(out_queue), .out_hash(out_hash)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference: sliding 32-bit key window fed one key bit per input bit.
  function automatic logic [31:0] ref_hash(input logic [95:0] s, input int nbits,
                                           input logic [319:0] k);
    logic [31:0] win = k[319:288];
    logic [31:0] r   = '0;
    for (int i = 0; i < nbits; i++) begin
      if (s[95-i]) r = r ^ win;
      win = {win[30:0], k[287-i]};
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_hash(input logic [1:0] ht, input logic [31:0] sa,
      input logic [31:0] da, input logic [15:0] sp, input logic [15:0] dp);
    if (ht == 2'd1) return ref_hash({sa, da, 32'h0}, 64, hash_key);
    if (ht == 2'd2) return ref_hash({sa, da, sp, dp}, 96, hash_key);
    return 32'h0;
  endfunction

  function automatic logic [7:0] exp_queue(input logic [1:0] ht, input logic [31:0] h,
      input logic [6:0] m, input logic [7:0] b);
    if (ht == 2'd0 || ht == 2'd3) return b;
    return b + {1'b0, tbl_model[h[6:0] & m]};
  endfunction

  task automatic drive(input logic [31:0] sa, input logic [31:0] da, input logic [15:0] sp,
      input logic [15:0] dp, input logic [1:0] ht, input logic [6:0] m, input logic [7:0] b);
    src_addr = sa; dst_addr = da; src_port = sp; dst_port = dp;
    hash_type = ht; hash_mask = m; base_cpu = b; pkt_valid = 1'b1;
  endtask

  // One packet; waits for its result and compares against the model.
  task automatic one_pkt(input string req, input logic [31:0] sa, input logic [31:0] da,
      input logic [15:0] sp, input logic [15:0] dp, input logic [1:0] ht,
      input logic [6:0] m, input logic [7:0] b, output logic [31:0] h);
    logic [31:0] eh;
    @(negedge clk);
    drive(sa, da, sp, dp, ht, m, b);
    eh = exp_hash(ht, sa, da, sp, dp);
    @(negedge clk);
    pkt_valid = 1'b0;
    @(negedge clk);
    chk({req, " R7 not early"}, out_valid, 1'b0);
    @(negedge clk);
    chk({req, " R7 valid"}, out_valid, 1'b1);
    chk({req, " hash"}, out_hash, eh);
    chk({req, " queue"}, out_queue, exp_queue(ht, eh, m, b));
    h = out_hash;
    @(negedge clk);
    chk({req, " R7 single pulse"}, out_valid, 1'b0);
  endtask

  task automatic write_tbl(input logic [6:0] a, input logic [6:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    tbl_model[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 out_valid in reset", out_valid, 1'b0);
    chk("R1 out_queue in reset", out_queue, 8'h0);
    chk("R1 out_hash in reset", out_hash, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 out_valid after release", out_valid, 1'b0);
  endtask

  // R3 R2 R1: published vector; table still zero so queue equals base.
  task automatic t_known_vector;
    logic [31:0] h;
    one_pkt("R3 R1 addr+port", 32'h420995bb, 32'ha18e6450, 16'd2794, 16'd1766,
            2'd2, 7'h7f, 8'd5, h);
    chk("R3 known hash addr+port", h, 32'h51ccc178);
    one_pkt("R2 addr only", 32'h420995bb, 32'ha18e6450, 16'd2794, 16'd1766,
            2'd1, 7'h7f, 8'd5, h);
    chk("R2 known hash addr only", h, 32'h323e8fc2);
    one_pkt("R2 ports ignored", 32'h420995bb, 32'ha18e6450, 16'hbeef, 16'h1234,
            2'd1, 7'h7f, 8'd5, h);
    chk("R2 ports do not change hash", h, 32'h323e8fc2);
  endtask

  task automatic t_fill_table;
    for (int i = 0; i < 128; i++) begin
      write_tbl(7'(i), 7'((i * 37 + 11) ^ (i >> 2)));
    end
  endtask

  task automatic t_lookup;
    logic [31:0] h;
    one_pkt("R5 full mask a", 32'h0a000001, 32'h0a000002, 16'd80, 16'd4321, 2'd2, 7'h7f, 8'd16, h);
    one_pkt("R5 full mask b", 32'hc0a80101, 32'h08080808, 16'd53, 16'd5353, 2'd2, 7'h7f, 8'd0, h);
    one_pkt("R4 narrow mask", 32'hc0a80101, 32'h08080808, 16'd53, 16'd5353, 2'd2, 7'h03, 8'd0, h);
    one_pkt("R4 zero mask", 32'hdeadbeef, 32'h01020304, 16'd9, 16'd10, 2'd1, 7'h00, 8'd3, h);
    one_pkt("R5 base wrap", 32'h11111111, 32'h22222222, 16'd1, 16'd2, 2'd2, 7'h7f, 8'd250, h);
  endtask

  task automatic t_bypass;
    logic [31:0] h;
    one_pkt("R6 type none", 32'h12345678, 32'h9abcdef0, 16'd7, 16'd8, 2'd0, 7'h7f, 8'd42, h);
    one_pkt("R6 type reserved", 32'h12345678, 32'h9abcdef0, 16'd7, 16'd8, 2'd3, 7'h7f, 8'd77, h);
  endtask

  // R8: rewrite the entry this tuple hits, then resend.
  task automatic t_rewrite;
    logic [31:0] h;
    one_pkt("R8 before write", 32'h0a0b0c0d, 32'h01010101, 16'd443, 16'd50000, 2'd2, 7'h7f, 8'd1, h);
    write_tbl(h[6:0], ~tbl_model[h[6:0]]);
    one_pkt("R8 after write", 32'h0a0b0c0d, 32'h01010101, 16'd443, 16'd50000, 2'd2, 7'h7f, 8'd1, h);
  endtask

  // R9: change mask and base the cycle after acceptance.
  task automatic t_sampled_cfg;
    logic [31:0] eh;
    @(negedge clk);
    drive(32'h55aa55aa, 32'h0f0f0f0f, 16'd100, 16'd200, 2'd2, 7'h7f, 8'd9);
    eh = exp_hash(2'd2, 32'h55aa55aa, 32'h0f0f0f0f, 16'd100, 16'd200);
    @(negedge clk);
    pkt_valid = 1'b0; hash_mask = 7'h00; base_cpu = 8'd200; hash_type = 2'd0;
    repeat (2) @(negedge clk);
    chk("R9 valid", out_valid, 1'b1);
    chk("R9 queue uses sampled config", out_queue, exp_queue(2'd2, eh, 7'h7f, 8'd9));
  endtask

  // R7: two packets on consecutive cycles with different settings.
  task automatic t_back_to_back;
    logic [31:0] h1, h2;
    @(negedge clk);
    drive(32'h01000001, 32'h02000002, 16'd11, 16'd22, 2'd2, 7'h7f, 8'd30);
    h1 = exp_hash(2'd2, 32'h01000001, 32'h02000002, 16'd11, 16'd22);
    @(negedge clk);
    drive(32'h03000003, 32'h04000004, 16'd33, 16'd44, 2'd1, 7'h0f, 8'd60);
    h2 = exp_hash(2'd1, 32'h03000003, 32'h04000004, 16'd33, 16'd44);
    @(negedge clk);
    pkt_valid = 1'b0;
    @(negedge clk);
    chk("R7 b2b first valid", out_valid, 1'b1);
    chk("R7 b2b first hash", out_hash, h1);
    chk("R7 b2b first queue", out_queue, exp_queue(2'd2, h1, 7'h7f, 8'd30));
    @(negedge clk);
    chk("R7 b2b second valid", out_valid, 1'b1);
    chk("R7 b2b second hash", out_hash, h2);
    chk("R7 b2b second queue", out_queue, exp_queue(2'd1, h2, 7'h0f, 8'd60));
    @(negedge clk);
    chk("R7 b2b idle after", out_valid, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    src_addr = '0; dst_addr = '0; src_port = '0; dst_port = '0;
    hash_type = 2'd0; hash_mask = '0; base_cpu = '0;
    hash_key = 320'h6d5a56da255b0ec24167253d43a38fb0d0ca2bcbae7b30b477cb2da38030f20c6a42b73bbeac01fa;
    for (int i = 0; i < 128; i++) tbl_model[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_known_vector();
    t_fill_table();
    t_lookup();
    t_bypass();
    t_rewrite();
    t_sampled_cfg();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule